// File: doc/BRIEF.md
# Home-Node Directory Coherence Controller

This block is the home node for a group of cache lines shared by a small number of cores. For every line it keeps a directory entry: a coherence state (uncached, shared or exclusive) and a presence vector with one bit per core. Cores present read-miss and write-miss requests through a valid/ready handshake. The controller looks up the entry and then acts on it. It may ask memory for the line and reply with data. It may send an intervention to the core that holds the line exclusively. It may invalidate every other sharer and grant exclusive ownership once all of those sharers have acknowledged.

The controller handles one transaction at a time. While a memory fetch, an intervention or an invalidation round is outstanding, `req_ready` is low and no new request is taken. Each kind of result has its own one-cycle pulse output. Memory is modelled as a fetch request with a later response pulse. Cores are modelled as a reply, intervention, invalidation and grant per message kind, plus intervention-done and acknowledgement inputs. Data payloads are not carried; only the control flow is modelled.

Top module: `dir_coherence_ctrl`

## Requirements
- R1: After reset every entry is uncached with an empty presence vector, all result pulses are low and `req_ready` is high.
- R2: A read of an uncached line pulses `mem_fetch_valid` with that line one cycle after acceptance. A `mem_rsp_valid` pulse then gives `reply_valid` to the requester one cycle later. The entry becomes shared with only the requester's bit set.
- R3: A read of a shared line pulses `reply_valid` to the requester one cycle after acceptance, with no memory fetch. The requester is added to the presence vector and the state stays shared.
- R4: A read of a line held exclusively by another core pulses `intv_valid` with the owner's index one cycle after acceptance. When `intv_done_valid` arrives, the entry becomes shared with both the former owner and the requester present. The controller sends no reply of its own for this read.
- R5: A write to a line that other cores hold pulses `inv_valid` one cycle after acceptance. `inv_mask` then holds bit i for each core i present in the entry, with the writer's own bit cleared.
- R6: During an invalidation round, no grant is issued until every core in the invalidation mask has acknowledged. `grant_valid` to the writer pulses exactly one cycle after the last acknowledgement is sampled.
- R7: A write to a line that no other core holds (uncached, or shared or exclusive with only the writer present) pulses `grant_valid` one cycle after acceptance.
- R8: After any grant the entry is exclusive, with only the writer's presence bit set.
- R9: While a fetch, intervention or invalidation round is pending, `req_ready` is low and a presented request is not accepted. At most one result pulse is high in any cycle.
- R10: An acknowledgement from a core that is not in the pending invalidation mask, or a repeated acknowledgement from a core that has already acknowledged, is ignored.
- R11: A read by the core that already holds the line exclusively is answered with `reply_valid` one cycle after acceptance, and the entry is left unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request presented |
| req_ready | output | 1 | Controller idle and able to accept |
| req_write | input | 1 | 1 = write miss, 0 = read miss |
| req_core | input | CID_W (3) | Requesting core index |
| req_line | input | LINE_W (4) | Requested line index |
| mem_fetch_valid | output | 1 | Memory fetch pulse |
| mem_fetch_line | output | LINE_W | Line to fetch |
| mem_rsp_valid | input | 1 | Memory data returned for the pending fetch |
| reply_valid | output | 1 | Data reply pulse to the requester |
| reply_core | output | CID_W | Core receiving the reply |
| reply_line | output | LINE_W | Line of the reply |
| intv_valid | output | 1 | Intervention pulse to the exclusive owner |
| intv_core | output | CID_W | Owner index |
| intv_line | output | LINE_W | Line of the intervention |
| intv_done_valid | input | 1 | Owner has forwarded data to the requester |
| inv_valid | output | 1 | Invalidation pulse |
| inv_mask | output | NUM_CORES (8) | Cores to invalidate, bit i = core i |
| inv_line | output | LINE_W | Line being invalidated |
| inv_ack_valid | input | 1 | Invalidation acknowledgement |
| inv_ack_core | input | CID_W | Core that acknowledges |
| grant_valid | output | 1 | Exclusive grant pulse |
| grant_core | output | CID_W | Core granted exclusive ownership |
| grant_line | output | LINE_W | Granted line |

## Verification
Some results are due one cycle after a request is accepted: the fetch, the direct reply, the intervention, the invalidation and the immediate grant. Others are due one cycle after the response that completes them, either the memory response or the final acknowledgement. The driver records the expected cycle for each result as it presents the stimulus. The monitor compares each output pulse against the head of that queue at the falling edge, checking kind, core, line, mask and arrival cycle. Any pulse that nothing expected, and any expected pulse that has not arrived by its cycle, counts as a failure. Directory contents are confirmed through later requests, for example an invalidation mask that reveals the presence vector.

// File: rtl/dir_pkg.sv
package dir_pkg;
   typedef enum logic [1:0] {
      DS_UNCACHED = 2'd0,
      DS_SHARED   = 2'd1,
      DS_EXCL     = 2'd2
   } dir_state_e;

   typedef enum logic [1:0] {
      F_IDLE      = 2'd0,
      F_MEM_WAIT  = 2'd1,
      F_INTV_WAIT = 2'd2,
      F_ACK_WAIT  = 2'd3
   } dir_fsm_e;
endpackage

// File: rtl/dir_popcount.sv
module dir_popcount #(
   parameter int W    = 8,
   localparam int CW  = $clog2(W + 1)
) (
   input  logic [W-1:0]  vec,
   output logic [CW-1:0] count
);
   logic [CW-1:0] part [W+1];

   assign part[0] = '0;
   for (genvar i = 0; i < W; i++) begin : g_chain
      assign part[i+1] = part[i] + CW'(vec[i]);
   end
   assign count = part[W];
endmodule

// File: rtl/dir_entry_store.sv
module dir_entry_store
   import dir_pkg::*;
#(
   parameter int NUM_LINES = 16,
   parameter int NUM_CORES = 8,
   localparam int LINE_W   = $clog2(NUM_LINES)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [LINE_W-1:0]    rd_line,
   output dir_state_e           rd_state,
   output logic [NUM_CORES-1:0] rd_pres,
   input  logic                 wr_en,
   input  logic [LINE_W-1:0]    wr_line,
   input  dir_state_e           wr_state,
   input  logic [NUM_CORES-1:0] wr_pres
);
   dir_state_e           st_q   [NUM_LINES];
   logic [NUM_CORES-1:0] pres_q [NUM_LINES];

   always_ff @(posedge clk) begin
      for (int i = 0; i < NUM_LINES; i++) begin
         if (!rst_n) begin
            st_q[i]   <= DS_UNCACHED;
            pres_q[i] <= '0;
         end else if (wr_en && wr_line == LINE_W'(i)) begin
            st_q[i]   <= wr_state;
            pres_q[i] <= wr_pres;
         end
      end
   end

   assign rd_state = st_q[rd_line];
   assign rd_pres  = pres_q[rd_line];

   AST_EXCL_SINGLE_OWNER: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_state == DS_EXCL) |-> ($countones(wr_pres) == 1)); // R8
   AST_WRITE_NOT_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |-> (wr_state != DS_UNCACHED && wr_pres != '0)); // R3
endmodule

// File: rtl/dir_ack_tracker.sv
module dir_ack_tracker #(
   parameter int NUM_CORES = 8,
   localparam int CID_W    = $clog2(NUM_CORES),
   localparam int CNT_W    = $clog2(NUM_CORES + 1)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 load,
   input  logic [NUM_CORES-1:0] load_mask,
   input  logic                 ack_valid,
   input  logic [CID_W-1:0]     ack_core,
   output logic                 ack_last
);
   logic [NUM_CORES-1:0] pending_q;
   logic [CNT_W-1:0]     remaining_q;
   logic [CNT_W-1:0]     load_count;
   logic                 hit;

   dir_popcount #(.W(NUM_CORES)) u_pop (
      .vec   (load_mask),
      .count (load_count)
   );

   assign hit      = ack_valid && pending_q[ack_core];
   assign ack_last = hit && (remaining_q == CNT_W'(1));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pending_q   <= '0;
         remaining_q <= '0;
      end else if (load) begin
         pending_q   <= load_mask;
         remaining_q <= load_count;
      end else if (hit) begin
         pending_q[ack_core] <= 1'b0;
         remaining_q         <= remaining_q - CNT_W'(1);
      end
   end

   AST_ACK_COUNT_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
      remaining_q == CNT_W'($countones(pending_q))); // R6
   AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      hit |-> (remaining_q != '0)); // R10
endmodule

// File: rtl/dir_coherence_ctrl.sv
module dir_coherence_ctrl
   import dir_pkg::*;
#(
   parameter int NUM_CORES = 8,
   parameter int NUM_LINES = 16,
   localparam int CID_W    = $clog2(NUM_CORES),
   localparam int LINE_W   = $clog2(NUM_LINES)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 req_valid,
   output logic                 req_ready,
   input  logic                 req_write,
   input  logic [CID_W-1:0]     req_core,
   input  logic [LINE_W-1:0]    req_line,
   output logic                 mem_fetch_valid,
   output logic [LINE_W-1:0]    mem_fetch_line,
   input  logic                 mem_rsp_valid,
   output logic                 reply_valid,
   output logic [CID_W-1:0]     reply_core,
   output logic [LINE_W-1:0]    reply_line,
   output logic                 intv_valid,
   output logic [CID_W-1:0]     intv_core,
   output logic [LINE_W-1:0]    intv_line,
   input  logic                 intv_done_valid,
   output logic                 inv_valid,
   output logic [NUM_CORES-1:0] inv_mask,
   output logic [LINE_W-1:0]    inv_line,
   input  logic                 inv_ack_valid,
   input  logic [CID_W-1:0]     inv_ack_core,
   output logic                 grant_valid,
   output logic [CID_W-1:0]     grant_core,
   output logic [LINE_W-1:0]    grant_line
);
   if (NUM_CORES < 2) begin : g_bad_cores
      $error("dir_coherence_ctrl: NUM_CORES must be at least 2");
   end
   if (NUM_LINES < 2 || (1 << LINE_W) != NUM_LINES) begin : g_bad_lines
      $error("dir_coherence_ctrl: NUM_LINES must be a power of two, at least 2");
   end

   dir_fsm_e             fsm_q, fsm_d;
   dir_state_e           rd_state, st_wstate;
   logic [NUM_CORES-1:0] rd_pres, st_wpres;
   logic                 st_we;
   logic [LINE_W-1:0]    st_wline;

   logic [CID_W-1:0]     cur_core_q, owner_idx_q, owner_idx;
   logic [LINE_W-1:0]    cur_line_q;
   logic [NUM_CORES-1:0] cur_bit_q, owner_bit_q, req_bit, others;
   logic                 accept, rd_uncached, rd_hit, rd_intv, wr_now, wr_inv;
   logic                 ack_last;
   logic                 fetch_q, reply_q, intv_q, inv_q, grant_q;
   logic [NUM_CORES-1:0] inv_mask_q;

   dir_entry_store #(.NUM_LINES(NUM_LINES), .NUM_CORES(NUM_CORES)) u_store (
      .clk      (clk),
      .rst_n    (rst_n),
      .rd_line  (req_line),
      .rd_state (rd_state),
      .rd_pres  (rd_pres),
      .wr_en    (st_we),
      .wr_line  (st_wline),
      .wr_state (st_wstate),
      .wr_pres  (st_wpres)
   );

   dir_ack_tracker #(.NUM_CORES(NUM_CORES)) u_acks (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (accept && wr_inv),
      .load_mask (others),
      .ack_valid (inv_ack_valid && fsm_q == F_ACK_WAIT),
      .ack_core  (inv_ack_core),
      .ack_last  (ack_last)
   );

   // request decode against the looked-up entry
   assign req_ready   = (fsm_q == F_IDLE);
   assign accept      = req_valid && req_ready;
   assign req_bit     = NUM_CORES'(1) << req_core;
   assign others      = rd_pres & ~req_bit;
   assign rd_uncached = !req_write && rd_state == DS_UNCACHED;
   assign rd_hit      = !req_write && (rd_state == DS_SHARED ||
                        (rd_state == DS_EXCL && rd_pres == req_bit));
   assign rd_intv     = !req_write && rd_state == DS_EXCL && rd_pres != req_bit;
   assign wr_now      = req_write && others == '0;
   assign wr_inv      = req_write && others != '0;

   always_comb begin
      owner_idx = '0;
      for (int i = 0; i < NUM_CORES; i++) begin
         if (rd_pres[i]) owner_idx = CID_W'(i);
      end
   end

   // directory write port
   always_comb begin
      st_we     = 1'b0;
      st_wline  = cur_line_q;
      st_wstate = DS_SHARED;
      st_wpres  = cur_bit_q;
      unique case (fsm_q)
         F_IDLE: begin
            st_wline = req_line;
            if (accept && rd_hit && rd_state == DS_SHARED) begin
               st_we    = 1'b1;
               st_wpres = rd_pres | req_bit;
            end else if (accept && wr_now) begin
               st_we     = 1'b1;
               st_wstate = DS_EXCL;
               st_wpres  = req_bit;
            end
         end
         F_MEM_WAIT:  st_we = mem_rsp_valid;
         F_INTV_WAIT: begin
            st_we    = intv_done_valid;
            st_wpres = owner_bit_q | cur_bit_q;
         end
         F_ACK_WAIT: begin
            st_we     = ack_last;
            st_wstate = DS_EXCL;
         end
         default: st_we = 1'b0;
      endcase
   end

   always_comb begin
      fsm_d = fsm_q;
      unique case (fsm_q)
         F_IDLE: begin
            if (accept && rd_uncached)  fsm_d = F_MEM_WAIT;
            else if (accept && rd_intv) fsm_d = F_INTV_WAIT;
            else if (accept && wr_inv)  fsm_d = F_ACK_WAIT;
         end
         F_MEM_WAIT:  if (mem_rsp_valid)   fsm_d = F_IDLE;
         F_INTV_WAIT: if (intv_done_valid) fsm_d = F_IDLE;
         F_ACK_WAIT:  if (ack_last)        fsm_d = F_IDLE;
         default:     fsm_d = F_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         fsm_q       <= F_IDLE;
         cur_core_q  <= '0;
         cur_line_q  <= '0;
         cur_bit_q   <= '0;
         owner_idx_q <= '0;
         owner_bit_q <= '0;
         fetch_q     <= 1'b0;
         reply_q     <= 1'b0;
         intv_q      <= 1'b0;
         inv_q       <= 1'b0;
         grant_q     <= 1'b0;
         inv_mask_q  <= '0;
      end else begin
         fsm_q <= fsm_d;
         if (accept) begin
            cur_core_q  <= req_core;
            cur_line_q  <= req_line;
            cur_bit_q   <= req_bit;
            owner_idx_q <= owner_idx;
            owner_bit_q <= rd_pres;
         end
         fetch_q    <= accept && rd_uncached;
         reply_q    <= (accept && rd_hit) || (fsm_q == F_MEM_WAIT && mem_rsp_valid);
         intv_q     <= accept && rd_intv;
         inv_q      <= accept && wr_inv;
         inv_mask_q <= (accept && wr_inv) ? others : '0;
         grant_q    <= (accept && wr_now) || (fsm_q == F_ACK_WAIT && ack_last);
      end
   end

   assign mem_fetch_valid = fetch_q;
   assign mem_fetch_line  = cur_line_q;
   assign reply_valid     = reply_q;
   assign reply_core      = cur_core_q;
   assign reply_line      = cur_line_q;
   assign intv_valid      = intv_q;
   assign intv_core       = owner_idx_q;
   assign intv_line       = cur_line_q;
   assign inv_valid       = inv_q;
   assign inv_mask        = inv_mask_q;
   assign inv_line        = cur_line_q;
   assign grant_valid     = grant_q;
   assign grant_core      = cur_core_q;
   assign grant_line      = cur_line_q;

   AST_FETCH_WAITS: assert property (@(posedge clk) disable iff (!rst_n)
      mem_fetch_valid |-> (fsm_q == F_MEM_WAIT)); // R2
   AST_INTV_WAITS: assert property (@(posedge clk) disable iff (!rst_n)
      intv_valid |-> (fsm_q == F_INTV_WAIT)); // R4
   AST_INV_EXCLUDES_WRITER: assert property (@(posedge clk) disable iff (!rst_n)
      inv_valid |-> (inv_mask != '0 && (inv_mask & cur_bit_q) == '0)); // R5
   AST_NO_EARLY_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
      (fsm_q == F_ACK_WAIT && !ack_last) |=> !grant_valid); // R6
   AST_ONE_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({fetch_q, reply_q, intv_q, inv_q, grant_q})); // R9
   AST_HOLD_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      (fsm_q != F_IDLE) |=> $stable(cur_core_q)); // R9
endmodule

// File: tb/dir_coherence_ctrl_tb.sv
`timescale 1ns/100ps
module dir_coherence_ctrl_tb;
   localparam int NC = 8;
   localparam int NL = 16;
   localparam int CW = $clog2(NC);
   localparam int LW = $clog2(NL);

   typedef enum int {EV_FETCH, EV_REPLY, EV_INTV, EV_INV, EV_GRANT} ev_kind_e;
   typedef struct {
      ev_kind_e kind;
      int       core;
      int       line;
      int       mask;
      int       due;
      string    tag;
   } ev_t;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          req_valid = 1'b0, req_write = 1'b0;
   logic [CW-1:0] req_core = '0, inv_ack_core = '0;
   logic [LW-1:0] req_line = '0;
   logic          mem_rsp_valid = 1'b0, intv_done_valid = 1'b0, inv_ack_valid = 1'b0;
   logic          req_ready, mem_fetch_valid, reply_valid, intv_valid, inv_valid, grant_valid;
   logic [LW-1:0] mem_fetch_line, reply_line, intv_line, inv_line, grant_line;
   logic [CW-1:0] reply_core, intv_core, grant_core;
   logic [NC-1:0] inv_mask;

   int  cyc = 0;
   int  checks = 0;
   int  fails = 0;
   ev_t exp_q[$];
   int  m_st [NL];   // 0 uncached, 1 shared, 2 exclusive (bench model only)
   int  m_pv [NL];

   dir_coherence_ctrl #(.NUM_CORES(NC), .NUM_LINES(NL)) u_dut (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
      .req_core(req_core), .req_line(req_line),
      .mem_fetch_valid(mem_fetch_valid), .mem_fetch_line(mem_fetch_line),
      .mem_rsp_valid(mem_rsp_valid),
      .reply_valid(reply_valid), .reply_core(reply_core), .reply_line(reply_line),
      .intv_valid(intv_valid), .intv_core(intv_core), .intv_line(intv_line),
      .intv_done_valid(intv_done_valid),
      .inv_valid(inv_valid), .inv_mask(inv_mask), .inv_line(inv_line),
      .inv_ack_valid(inv_ack_valid), .inv_ack_core(inv_ack_core),
      .grant_valid(grant_valid), .grant_core(grant_core), .grant_line(grant_line)
   );

   always #2.5 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   task automatic check(string tag, int act, int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d (cycle %0d)", tag, act, exp, cyc);
      end
   endtask

   task automatic push(ev_kind_e k, int c, int l, int m, string tag);
      ev_t e;
      e.kind = k; e.core = c; e.line = l; e.mask = m; e.due = cyc + 1; e.tag = tag;
      exp_q.push_back(e);
   endtask

   // monitor: compares every result pulse with the head of the queue
   always @(negedge clk) begin
      if (rst_n) begin
         int n;
         ev_t g;
         n = int'(mem_fetch_valid) + int'(reply_valid) + int'(intv_valid)
           + int'(inv_valid) + int'(grant_valid);
         if (n > 1) begin
            checks++; fails++;
            $display("FAIL R9: %0d result pulses in cycle %0d, expected at most 1", n, cyc);
         end else if (n == 1) begin
            g.mask = 0;
            if (mem_fetch_valid) begin g.kind = EV_FETCH; g.core = 0; g.line = int'(mem_fetch_line); end
            else if (reply_valid) begin g.kind = EV_REPLY; g.core = int'(reply_core); g.line = int'(reply_line); end
            else if (intv_valid) begin g.kind = EV_INTV; g.core = int'(intv_core); g.line = int'(intv_line); end
            else if (inv_valid) begin g.kind = EV_INV; g.core = 0; g.line = int'(inv_line); g.mask = int'(inv_mask); end
            else begin g.kind = EV_GRANT; g.core = int'(grant_core); g.line = int'(grant_line); end
            checks++;
            if (exp_q.size() == 0) begin
               fails++;
               $display("FAIL R9/R10: unexpected pulse kind %0d core %0d line %0d mask %h cycle %0d, expected none",
                        g.kind, g.core, g.line, g.mask, cyc);
            end else begin
               ev_t e;
               e = exp_q.pop_front();
               if (e.kind != g.kind || e.core != g.core || e.line != g.line ||
                   e.mask != g.mask || e.due != cyc) begin
                  fails++;
                  $display("FAIL %s: actual kind %0d core %0d line %0d mask %h cycle %0d, expected kind %0d core %0d line %0d mask %h cycle %0d",
                           e.tag, g.kind, g.core, g.line, g.mask, cyc,
                           e.kind, e.core, e.line, e.mask, e.due);
               end
            end
         end else if (exp_q.size() != 0 && exp_q[0].due < cyc) begin
            ev_t e;
            e = exp_q.pop_front();
            checks++; fails++;
            $display("FAIL %s: actual no pulse by cycle %0d, expected kind %0d core %0d line %0d at cycle %0d",
                     e.tag, cyc, e.kind, e.core, e.line, e.due);
         end
      end
   end

   task automatic do_req(string tag, bit w, int c, int l);
      int bitc, oth;
      @(negedge clk);
      while (!req_ready) @(negedge clk);
      req_valid = 1'b1; req_write = w; req_core = CW'(c); req_line = LW'(l);
      bitc = 1 << c;
      oth  = m_pv[l] & ~bitc;
      if (!w) begin
         if (m_st[l] == 0) push(EV_FETCH, 0, l, 0, tag);
         else if (m_st[l] == 1) begin push(EV_REPLY, c, l, 0, tag); m_pv[l] |= bitc; end
         else if (m_pv[l] == bitc) push(EV_REPLY, c, l, 0, tag);
         else begin
            int own = 0;
            for (int i = 0; i < NC; i++) if (m_pv[l][i]) own = i;
            push(EV_INTV, own, l, 0, tag);
         end
      end else if (oth == 0) begin
         push(EV_GRANT, c, l, 0, tag);
         m_st[l] = 2; m_pv[l] = bitc;
      end else begin
         push(EV_INV, 0, l, oth, tag);
      end
      @(negedge clk);
      req_valid = 1'b0;
   endtask

   task automatic mem_respond(string tag, int c, int l);
      @(negedge clk);
      mem_rsp_valid = 1'b1;
      push(EV_REPLY, c, l, 0, tag);
      m_st[l] = 1; m_pv[l] = 1 << c;
      @(negedge clk);
      mem_rsp_valid = 1'b0;
   endtask

   task automatic owner_done(int own, int c, int l);
      @(negedge clk);
      intv_done_valid = 1'b1;
      m_st[l] = 1; m_pv[l] = (1 << own) | (1 << c);
      @(negedge clk);
      intv_done_valid = 1'b0;
   endtask

   task automatic send_ack(string tag, int from, bit last, int wc, int l);
      @(negedge clk);
      inv_ack_valid = 1'b1; inv_ack_core = CW'(from);
      if (last) begin
         push(EV_GRANT, wc, l, 0, tag);
         m_st[l] = 2; m_pv[l] = 1 << wc;
      end
      @(negedge clk);
      inv_ack_valid = 1'b0;
   endtask

   task automatic report();
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   endtask

   initial begin
      #(5.0 * 150000);
      checks++; fails++;
      $display("FAIL watchdog: actual run still busy at cycle %0d, expected completion", cyc);
      report();
   end

   initial begin
      for (int i = 0; i < NL; i++) begin m_st[i] = 0; m_pv[i] = 0; end
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1: idle outputs and ready after reset
      check("R1 ready", int'(req_ready), 1);
      check("R1 pulses", int'({mem_fetch_valid, reply_valid, intv_valid, inv_valid, grant_valid}), 0);

      // R1/R2: untouched line is uncached, so a read fetches
      do_req("R2 fetch", 1'b0, 1, 3);
      // R9: busy during fetch, write presented but not taken
      req_valid = 1'b1; req_write = 1'b1; req_core = 3'd5; req_line = 4'd3;
      for (int k = 0; k < 3; k++) begin
         check("R9 ready low while fetching", int'(req_ready), 0);
         @(negedge clk);
      end
      req_valid = 1'b0;
      mem_respond("R2 reply", 1, 3);

      // R3: shared-line reads
      do_req("R3 reply c4", 1'b0, 4, 3);
      do_req("R3 reply c6", 1'b0, 6, 3);

      // R5: writer c4 invalidates c1 and c6 only (mask bit i = core i)
      do_req("R5 inv mask", 1'b1, 4, 3);
      // R10: non-pending and duplicate acks are ignored
      send_ack("R10 stray", 2, 1'b0, 4, 3);
      send_ack("R6 ack c1", 1, 1'b0, 4, 3);
      send_ack("R10 dup", 1, 1'b0, 4, 3);
      @(negedge clk);
      check("R10 still waiting", int'(req_ready), 0);
      send_ack("R6 grant after last ack", 6, 1'b1, 4, 3);

      // R8: line now exclusive to c4, a read intervenes to c4
      do_req("R8 intv to owner", 1'b0, 0, 3);
      check("R9 ready low during intervention", int'(req_ready), 0);
      owner_done(4, 0, 3);
      // R4: entry shared by c0 and c4, seen through the invalidation mask
      do_req("R4 shared owner+reader", 1'b1, 7, 3);
      send_ack("R6 ack c4", 4, 1'b0, 7, 3);
      send_ack("R6 grant c7", 0, 1'b1, 7, 3);

      // R11: owner re-reads, entry unchanged
      do_req("R11 owner reply", 1'b0, 7, 3);
      // R7: owner write, no other sharers
      do_req("R7 owner grant", 1'b1, 7, 3);
      // R7: write to uncached line
      do_req("R7 uncached grant", 1'b1, 2, 9);
      // R8: c2 is sole exclusive owner of line 9
      do_req("R8 intv line 9", 1'b0, 5, 9);
      owner_done(2, 5, 9);
      // R2: other lines still uncached
      do_req("R2 fetch line 0", 1'b0, 3, 0);
      mem_respond("R2 reply line 0", 3, 0);

      repeat (4) @(negedge clk);
      check("R9 all results delivered", exp_q.size(), 0);
      check("R1 ready at end", int'(req_ready), 1);
      report();
   end
endmodule